// File: doc/BRIEF.md
# Address-Decoding Bus Matrix

This block sits between a 32-bit processor core and four downstream ports. The core has three requesters: the data access unit, the instruction fetch unit and the debug access path. The ports are an instruction-code port, a data-code port, a system port and an external peripheral port. Every request address is decoded against a fixed memory map. The map and the type of requester together select one port, or no port at all. When two or more requesters want the same port in the same cycle, a fixed-priority arbiter chooses one of them. The others see a low done signal and wait.

Each requester holds its request, address and write data stable until it sees its done signal. Each port is a simplified single-phase handshake: valid, address and controls stay stable until the target raises ready, and ready marks the cycle in which the transfer completes. The three memory ports carry the full address. The peripheral port carries only the low 20 address bits, the write flag and the data, because it always moves whole words. Requests that decode to no port, and peripheral requests that break the port's rules, are answered with an error one cycle later and never reach a port.

Top module: `busMatrix`

## Requirements
- R1: A fetch to 0x00000000–0x1FFFFFFF appears on the instruction-code port. The address bits [1:0] on that port are forced to zero, and the port's read data returns to the fetch unit unchanged.
- R2: A data or debug access to 0x00000000–0x1FFFFFFF appears on the data-code port with its own address, write flag and write data. A debug access never reaches the instruction-code port.
- R3: Any requester whose address lies in 0x20000000–0xDFFFFFFF or 0xE0100000–0xFFFFFFFF reaches the system port.
- R4: A legal data or debug access to 0xE0040000–0xE00FFFFF reaches the peripheral port. The port address equals the request address bits [19:0].
- R5: On the system port, requests that arrive together are served in this order: data, then fetch, then debug. Each one completes only after the one before it.
- R6: On the data-code and peripheral ports, a data access that collides with a debug access goes first. Debug waits until that data transfer completes.
- R7: A peripheral-window request is refused with an error when its size code is not word (size encoding: 2'b00 byte, 2'b01 halfword, 2'b10 word). A data request in that window is also refused when the privilege input is low. Debug requests are always treated as privileged. A refused request raises done together with error exactly one cycle after it is presented, and no port is driven.
- R8: A request to 0xE0000000–0xE003FFFF from any requester, and a fetch to 0xE0040000–0xE00FFFFF, get the same one-cycle error with no port driven.
- R9: Once a transfer is on a port, it keeps that port until the port returns ready. A higher-priority request that arrives meanwhile waits.
- R10: With the core big-endian input high, a word-sized data-requester transfer on the instruction-code, data-code or system port is byte-reversed in both directions. Peripheral-port transfers and debug transfers are never reversed.
- R11: Requests that target different ports are served in the same cycle, independently of each other.
- R12: An error flag that a port returns with ready goes back to the owning requester as error together with done.
- R13: During and right after reset, no port is valid and no requester sees done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| coreBigEnd | input | 1 | Core data endianness, 1 = big-endian |
| dataReq | input | 1 | Data requester: request |
| dataAddr | input | 32 | Data requester: address |
| dataWrite | input | 1 | Data requester: 1 = write |
| dataSize | input | 2 | Data requester: size code |
| dataPriv | input | 1 | Data requester: privileged access |
| dataWdata | input | DW | Data requester: write data |
| dataDone | output | 1 | Data requester: transfer finished |
| dataErr | output | 1 | Data requester: error response |
| dataRdata | output | DW | Data requester: read data |
| fetchReq | input | 1 | Fetch requester: request |
| fetchAddr | input | 32 | Fetch requester: address |
| fetchDone | output | 1 | Fetch requester: transfer finished |
| fetchErr | output | 1 | Fetch requester: error response |
| fetchRdata | output | DW | Fetch requester: read data |
| dbgReq | input | 1 | Debug requester: request |
| dbgAddr | input | 32 | Debug requester: address |
| dbgWrite | input | 1 | Debug requester: 1 = write |
| dbgSize | input | 2 | Debug requester: size code |
| dbgWdata | input | DW | Debug requester: write data |
| dbgDone | output | 1 | Debug requester: transfer finished |
| dbgErr | output | 1 | Debug requester: error response |
| dbgRdata | output | DW | Debug requester: read data |
| icValid | output | 1 | Instruction-code port: transfer valid |
| icAddr | output | 32 | Instruction-code port: word address |
| icReady | input | 1 | Instruction-code port: transfer complete |
| icErr | input | 1 | Instruction-code port: error |
| icRdata | input | DW | Instruction-code port: read data |
| dcValid | output | 1 | Data-code port: transfer valid |
| dcAddr | output | 32 | Data-code port: address |
| dcWrite | output | 1 | Data-code port: write |
| dcSize | output | 2 | Data-code port: size code |
| dcWdata | output | DW | Data-code port: write data |
| dcReady | input | 1 | Data-code port: transfer complete |
| dcErr | input | 1 | Data-code port: error |
| dcRdata | input | DW | Data-code port: read data |
| sysValid | output | 1 | System port: transfer valid |
| sysAddr | output | 32 | System port: address |
| sysWrite | output | 1 | System port: write |
| sysSize | output | 2 | System port: size code |
| sysWdata | output | DW | System port: write data |
| sysReady | input | 1 | System port: transfer complete |
| sysErr | input | 1 | System port: error |
| sysRdata | input | DW | System port: read data |
| ppValid | output | 1 | Peripheral port: transfer valid |
| ppAddr | output | PPB_AW | Peripheral port: low address bits |
| ppWrite | output | 1 | Peripheral port: write |
| ppWdata | output | DW | Peripheral port: write data |
| ppReady | input | 1 | Peripheral port: transfer complete |
| ppErr | input | 1 | Peripheral port: error |
| ppRdata | input | DW | Peripheral port: read data |

## Verification
The main sweep issues a lone request from each of the three requesters to addresses on both sides of every region edge. It is repeated with zero and two wait states and with both endianness settings. Together these runs show whether the decode picks the right port or none, whether the port-side address is trimmed correctly, and whether latency follows the target's wait count while byte reversal follows only the data requester. Separate patterns send byte, halfword and unprivileged accesses to the peripheral window, which separates the legality checks from the decode itself. Timed collision patterns start requests in the same cycle, or one cycle apart, against ports with wait states; the completion cycles then show the priority order, the hold on an in-flight transfer, and the independence of different ports.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int ADDR_W = 32;
  localparam int NREQ   = 3;
  localparam int NPORT  = 4;

  // requester index doubles as priority rank: lower index wins
  localparam int R_DATA  = 0;
  localparam int R_FETCH = 1;
  localparam int R_DBG   = 2;

  localparam int P_IC  = 0;
  localparam int P_DC  = 1;
  localparam int P_SYS = 2;
  localparam int P_PPB = 3;

  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [2:0] {
    TGT_IC   = 3'd0,
    TGT_DC   = 3'd1,
    TGT_SYS  = 3'd2,
    TGT_PPB  = 3'd3,
    TGT_NONE = 3'd4
  } target_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NPORT-1:0][NREQ-1:0] grant;
    logic [NREQ-1:0]            errNow;
  } ctrlStrb_t;

  function automatic target_e decodeTarget(input logic [ADDR_W-1:0] a, input int r);
    if (a[31:29] == 3'b000) begin
      decodeTarget = (r == R_FETCH) ? TGT_IC : TGT_DC;
    end else if (a[31:20] == 12'hE00) begin
      if (a[19:18] == 2'b00 || r == R_FETCH) decodeTarget = TGT_NONE;
      else                                   decodeTarget = TGT_PPB;
    end else begin
      decodeTarget = TGT_SYS;
    end
  endfunction
endpackage

// File: rtl/bm_arb.sv
module bm_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] cand,
  input  logic         ready,
  output logic [N-1:0] grant
);
  logic         busyQ;
  logic [N-1:0] ownerQ;
  logic [N-1:0] pick;

  // lowest set bit = highest priority
  assign pick  = cand & (~cand + N'(1));
  assign grant = busyQ ? ownerQ : pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      ownerQ <= '0;
    end else begin
      busyQ  <= (|grant) && !ready;
      ownerQ <= grant;
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R9
  hold_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|grant) && !ready) |=> (grant == $past(grant)));

  // R5
  data_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && cand[0]) |-> grant[0]);
endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NREQ-1:0]               req,
  input  logic [NREQ-1:0][ADDR_W-1:0]   addr,
  input  logic [NREQ-1:0][1:0]          size,
  input  logic                          dataPriv,
  input  logic [NPORT-1:0]              portReady,
  output ctrlStrb_t                     strb
);
  target_e                    tgt [NREQ];
  logic [NREQ-1:0]            bad;
  logic [NPORT-1:0][NREQ-1:0] cand;
  logic [NPORT-1:0][NREQ-1:0] grantW;
  logic [NREQ-1:0]            errQ;

  always_comb begin
    bad  = '0;
    cand = '0;
    for (int r = 0; r < NREQ; r++) begin
      tgt[r] = decodeTarget(addr[r], r);
      bad[r] = (tgt[r] == TGT_NONE) ||
               (tgt[r] == TGT_PPB &&
                (size[r] != SZ_WORD || (r == R_DATA && !dataPriv)));
      for (int p = 0; p < NPORT; p++)
        cand[p][r] = req[r] && !bad[r] && (int'(tgt[r]) == p);
    end
  end

  // a refused request is answered one cycle later, once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= '0;
    else       errQ <= req & bad & ~errQ;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_arb
    bm_arb #(.N(NREQ)) u_arb (
      .clk   (clk),
      .rstN  (rstN),
      .cand  (cand[p]),
      .ready (portReady[p]),
      .grant (grantW[p])
    );
  end

  assign strb.grant  = grantW;
  assign strb.errNow = errQ;

  for (genvar r = 0; r < NREQ; r++) begin : g_chk
    logic anyGrant;
    always_comb begin
      anyGrant = 1'b0;
      for (int p = 0; p < NPORT; p++) anyGrant = anyGrant | grantW[p][r];
    end
    // R8
    err_no_transfer_chk: assert property (@(posedge clk) disable iff (!rstN)
      errQ[r] |-> !anyGrant);
  end
endmodule

// File: rtl/bm_dpath.sv
module bm_dpath
  import bm_pkg::*;
#(
  parameter int DW = 32
) (
  input  ctrlStrb_t                     strb,
  input  logic                          coreBigEnd,
  input  logic [NREQ-1:0][ADDR_W-1:0]   reqAddr,
  input  logic [NREQ-1:0]               reqWrite,
  input  logic [NREQ-1:0][1:0]          reqSize,
  input  logic [NREQ-1:0][DW-1:0]       reqWdata,
  output logic [NREQ-1:0]               reqDone,
  output logic [NREQ-1:0]               reqErr,
  output logic [NREQ-1:0][DW-1:0]       reqRdata,
  output logic [NPORT-1:0]              portValid,
  output logic [NPORT-1:0]              portWrite,
  output logic [NPORT-1:0][ADDR_W-1:0]  portAddr,
  output logic [NPORT-1:0][1:0]         portSize,
  output logic [NPORT-1:0][DW-1:0]      portWdata,
  input  logic [NPORT-1:0]              portReady,
  input  logic [NPORT-1:0]              portErr,
  input  logic [NPORT-1:0][DW-1:0]      portRdata
);
  localparam int NBYTE = DW / 8;

  function automatic logic [DW-1:0] byteRev(input logic [DW-1:0] x);
    logic [DW-1:0] y;
    for (int b = 0; b < NBYTE; b++) y[8*b +: 8] = x[8*(NBYTE-1-b) +: 8];
    return y;
  endfunction

  logic swapData;
  assign swapData = coreBigEnd && (reqSize[R_DATA] == SZ_WORD);

  // request -> port
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      portValid[p] = |strb.grant[p];
      portAddr[p]  = '0;
      portWrite[p] = 1'b0;
      portSize[p]  = '0;
      portWdata[p] = '0;
      for (int r = 0; r < NREQ; r++) begin
        if (strb.grant[p][r]) begin
          portAddr[p]  = reqAddr[r];
          portWrite[p] = reqWrite[r];
          portSize[p]  = reqSize[r];
          portWdata[p] = (r == R_DATA && swapData && p != P_PPB) ?
                         byteRev(reqWdata[r]) : reqWdata[r];
        end
      end
    end
  end

  // port -> requester
  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      reqDone[r]  = strb.errNow[r];
      reqErr[r]   = strb.errNow[r];
      reqRdata[r] = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (strb.grant[p][r]) begin
          reqDone[r]  = reqDone[r] | portReady[p];
          reqErr[r]   = reqErr[r] | (portReady[p] & portErr[p]);
          reqRdata[r] = (r == R_DATA && swapData && p != P_PPB) ?
                        byteRev(portRdata[p]) : portRdata[p];
        end
      end
    end
  end
endmodule

// File: rtl/busMatrix.sv
module busMatrix
  import bm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PPB_AW = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreBigEnd,
  input  logic              dataReq,
  input  logic [31:0]       dataAddr,
  input  logic              dataWrite,
  input  logic [1:0]        dataSize,
  input  logic              dataPriv,
  input  logic [DW-1:0]     dataWdata,
  output logic              dataDone,
  output logic              dataErr,
  output logic [DW-1:0]     dataRdata,
  input  logic              fetchReq,
  input  logic [31:0]       fetchAddr,
  output logic              fetchDone,
  output logic              fetchErr,
  output logic [DW-1:0]     fetchRdata,
  input  logic              dbgReq,
  input  logic [31:0]       dbgAddr,
  input  logic              dbgWrite,
  input  logic [1:0]        dbgSize,
  input  logic [DW-1:0]     dbgWdata,
  output logic              dbgDone,
  output logic              dbgErr,
  output logic [DW-1:0]     dbgRdata,
  output logic              icValid,
  output logic [31:0]       icAddr,
  input  logic              icReady,
  input  logic              icErr,
  input  logic [DW-1:0]     icRdata,
  output logic              dcValid,
  output logic [31:0]       dcAddr,
  output logic              dcWrite,
  output logic [1:0]        dcSize,
  output logic [DW-1:0]     dcWdata,
  input  logic              dcReady,
  input  logic              dcErr,
  input  logic [DW-1:0]     dcRdata,
  output logic              sysValid,
  output logic [31:0]       sysAddr,
  output logic              sysWrite,
  output logic [1:0]        sysSize,
  output logic [DW-1:0]     sysWdata,
  input  logic              sysReady,
  input  logic              sysErr,
  input  logic [DW-1:0]     sysRdata,
  output logic              ppValid,
  output logic [PPB_AW-1:0] ppAddr,
  output logic              ppWrite,
  output logic [DW-1:0]     ppWdata,
  input  logic              ppReady,
  input  logic              ppErr,
  input  logic [DW-1:0]     ppRdata
);
  logic [NREQ-1:0]              reqV, reqW, doneV, errV;
  logic [NREQ-1:0][ADDR_W-1:0]  reqA;
  logic [NREQ-1:0][1:0]         reqS;
  logic [NREQ-1:0][DW-1:0]      reqWd, reqRd;
  logic [NPORT-1:0]             pValid, pWrite, pReady, pErr;
  logic [NPORT-1:0][ADDR_W-1:0] pAddr;
  logic [NPORT-1:0][1:0]        pSize;
  logic [NPORT-1:0][DW-1:0]     pWdata, pRdata;
  ctrlStrb_t                    strb;

  // requester order: data, fetch, debug (also the priority order)
  assign reqV  = {dbgReq, fetchReq, dataReq};
  assign reqA  = {dbgAddr, fetchAddr, dataAddr};
  assign reqW  = {dbgWrite, 1'b0, dataWrite};
  assign reqS  = {dbgSize, SZ_WORD, dataSize};
  assign reqWd = {dbgWdata, {DW{1'b0}}, dataWdata};

  assign pReady = {ppReady, sysReady, dcReady, icReady};
  assign pErr   = {ppErr, sysErr, dcErr, icErr};
  assign pRdata = {ppRdata, sysRdata, dcRdata, icRdata};

  bm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .req       (reqV),
    .addr      (reqA),
    .size      (reqS),
    .dataPriv  (dataPriv),
    .portReady (pReady),
    .strb      (strb)
  );

  bm_dpath #(.DW(DW)) u_dpath (
    .strb       (strb),
    .coreBigEnd (coreBigEnd),
    .reqAddr    (reqA),
    .reqWrite   (reqW),
    .reqSize    (reqS),
    .reqWdata   (reqWd),
    .reqDone    (doneV),
    .reqErr     (errV),
    .reqRdata   (reqRd),
    .portValid  (pValid),
    .portWrite  (pWrite),
    .portAddr   (pAddr),
    .portSize   (pSize),
    .portWdata  (pWdata),
    .portReady  (pReady),
    .portErr    (pErr),
    .portRdata  (pRdata)
  );

  assign dataDone   = doneV[R_DATA];
  assign dataErr    = errV[R_DATA];
  assign dataRdata  = reqRd[R_DATA];
  assign fetchDone  = doneV[R_FETCH];
  assign fetchErr   = errV[R_FETCH];
  assign fetchRdata = reqRd[R_FETCH];
  assign dbgDone    = doneV[R_DBG];
  assign dbgErr     = errV[R_DBG];
  assign dbgRdata   = reqRd[R_DBG];

  assign icValid  = pValid[P_IC];
  assign icAddr   = {pAddr[P_IC][ADDR_W-1:2], 2'b00};

  assign dcValid  = pValid[P_DC];
  assign dcAddr   = pAddr[P_DC];
  assign dcWrite  = pWrite[P_DC];
  assign dcSize   = pSize[P_DC];
  assign dcWdata  = pWdata[P_DC];

  assign sysValid = pValid[P_SYS];
  assign sysAddr  = pAddr[P_SYS];
  assign sysWrite = pWrite[P_SYS];
  assign sysSize  = pSize[P_SYS];
  assign sysWdata = pWdata[P_SYS];

  assign ppValid  = pValid[P_PPB];
  assign ppAddr   = pAddr[P_PPB][PPB_AW-1:0];
  assign ppWrite  = pWrite[P_PPB];
  assign ppWdata  = pWdata[P_PPB];
endmodule

// File: tb/test_busMatrix.sv
module test_busMatrix;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic bigEnd = 1'b0;
  logic dataPriv = 1'b1;
  logic [2:0] rq = '0;
  logic [2:0] rw = '0;
  logic [2:0][31:0] ra = '0;
  logic [2:0][31:0] rwd = '0;
  logic [2:0][1:0] rs = '0;
  logic [2:0] dn, er;
  logic [2:0][31:0] rd;

  logic [3:0] pv, prdy, perr;
  logic [3:0][31:0] pa, pwd, prd;
  logic [31:0] icA, dcA, sysA, dcWd, sysWd, ppWd;
  logic [19:0] ppA;
  logic dcW, sysW, ppW;
  logic [1:0] dcS, sysS;
  logic [3:0] errOn = '0;
  int waitLen [4];
  int cnt [4];

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  assign pa  = {{12'h000, ppA}, sysA, dcA, icA};
  assign pwd = {ppWd, sysWd, dcWd, 32'h0};

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      prdy[p] = pv[p] && (cnt[p] >= waitLen[p]);
      perr[p] = pv[p] && errOn[p];
      prd[p]  = pa[p] ^ (32'hC3C3_0000 | 32'(p));
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 4; p++) cnt[p] <= (pv[p] && !prdy[p]) ? cnt[p] + 1 : 0;
  end

  busMatrix i_busMatrix (
    .clk(clk), .rstN(rstN), .coreBigEnd(bigEnd),
    .dataReq(rq[0]), .dataAddr(ra[0]), .dataWrite(rw[0]), .dataSize(rs[0]),
    .dataPriv(dataPriv), .dataWdata(rwd[0]),
    .dataDone(dn[0]), .dataErr(er[0]), .dataRdata(rd[0]),
    .fetchReq(rq[1]), .fetchAddr(ra[1]),
    .fetchDone(dn[1]), .fetchErr(er[1]), .fetchRdata(rd[1]),
    .dbgReq(rq[2]), .dbgAddr(ra[2]), .dbgWrite(rw[2]), .dbgSize(rs[2]), .dbgWdata(rwd[2]),
    .dbgDone(dn[2]), .dbgErr(er[2]), .dbgRdata(rd[2]),
    .icValid(pv[0]), .icAddr(icA), .icReady(prdy[0]), .icErr(perr[0]), .icRdata(prd[0]),
    .dcValid(pv[1]), .dcAddr(dcA), .dcWrite(dcW), .dcSize(dcS), .dcWdata(dcWd),
    .dcReady(prdy[1]), .dcErr(perr[1]), .dcRdata(prd[1]),
    .sysValid(pv[2]), .sysAddr(sysA), .sysWrite(sysW), .sysSize(sysS), .sysWdata(sysWd),
    .sysReady(prdy[2]), .sysErr(perr[2]), .sysRdata(prd[2]),
    .ppValid(pv[3]), .ppAddr(ppA), .ppWrite(ppW), .ppWdata(ppWd),
    .ppReady(prdy[3]), .ppErr(perr[3]), .ppRdata(prd[3])
  );

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // expected port from the memory map: -1 = refused
  function automatic int expPort(input int r, input logic [31:0] a, input logic [1:0] s, input logic pr);
    if (a <= 32'h1FFF_FFFF) return (r == 1) ? 0 : 1;
    if (a >= 32'hE000_0000 && a < 32'hE004_0000) return -1;
    if (a >= 32'hE004_0000 && a < 32'hE010_0000) begin
      if (r == 1 || s != 2'b10 || (r == 0 && !pr)) return -1;
      return 3;
    end
    return 2;
  endfunction

  function automatic string tagOf(input int p);
    case (p)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input int r, input logic [31:0] a, input logic w, input logic [1:0] s,
                       input logic [31:0] wd, output int cyc, output int ps, output logic e,
                       output logic [31:0] d, output logic [31:0] sa, output logic [31:0] sw,
                       output logic anyV);
    rq[r] = 1'b1; ra[r] = a; rw[r] = w; rs[r] = s; rwd[r] = wd;
    cyc = 0; ps = -1; sa = '0; sw = '0;
    #1;
    while (!dn[r] && cyc < 40) begin
      @(negedge clk); #1;
      cyc++;
    end
    e = er[r]; d = rd[r]; anyV = |pv;
    for (int p = 0; p < 4; p++)
      if (pv[p] && prdy[p]) begin ps = p; sa = pa[p]; sw = pwd[p]; end
    @(posedge clk); #1;
    rq[r] = 1'b0;
  endtask

  task automatic setWait(input int w);
    for (int p = 0; p < 4; p++) waitLen[p] = w;
  endtask

  logic [31:0] addrs [11] = '{32'h0000_0000, 32'h1FFF_FFFC, 32'h2000_0000, 32'h8000_1234,
                              32'hDFFF_FFFC, 32'hE000_0000, 32'hE003_FFFC, 32'hE004_0000,
                              32'hE00F_FFFC, 32'hE010_0000, 32'hFFFF_FFFC};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int cyc, c0, c1, c2, ps, ep;
    logic e, anyV;
    logic [31:0] d, sa, sw, base, expD, expW;
    string tg;
    setWait(0);

    // R13 reset
    repeat (2) @(negedge clk);
    #1;
    chk(pv == 4'b0, "R13", "port valid in reset", {28'h0, pv}, 32'h0);
    chk(dn == 3'b0, "R13", "done in reset", {29'h0, dn}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    chk(pv == 4'b0, "R13", "port valid after reset", {28'h0, pv}, 32'h0);
    chk(dn == 3'b0, "R13", "done after reset", {29'h0, dn}, 32'h0);

    // map sweep: R1 R2 R3 R4 R8 R10
    for (int wl = 0; wl <= 2; wl += 2) begin
      for (int be = 0; be < 2; be++) begin
        for (int r = 0; r < 3; r++) begin
          for (int i = 0; i < 11; i++) begin
            logic w;
            logic [31:0] a;
            setWait(wl);
            bigEnd = be[0];
            a = addrs[i];
            w = (r != 1) && (i % 2 == 1);
            @(negedge clk);
            issue(r, a, w, 2'b10, a ^ 32'h1357_9BDF, cyc, ps, e, d, sa, sw, anyV);
            ep = expPort(r, a, 2'b10, 1'b1);
            tg = tagOf(ep);
            if (ep < 0) begin
              chk(e == 1'b1, tg, "error flag", {31'h0, e}, 32'h1);
              chk(cyc == 1, tg, "error latency", cyc, 1);
              chk(!anyV, tg, "port driven on refusal", {31'h0, anyV}, 32'h0);
            end else begin
              base = (ep == 0) ? (a & 32'hFFFF_FFFC) : (ep == 3) ? (a & 32'h000F_FFFF) : a;
              expD = base ^ (32'hC3C3_0000 | 32'(ep));
              expW = a ^ 32'h1357_9BDF;
              if (r == 0 && be == 1 && ep != 3) begin
                expD = rev(expD); expW = rev(expW); tg = "R10";
              end
              chk(ps == ep, tg, "port chosen", ps, ep);
              chk(e == 1'b0, tg, "error flag", {31'h0, e}, 32'h0);
              chk(cyc == wl, tg, "latency", cyc, wl);
              chk(sa == base, tg, "port address", sa, base);
              chk(d == expD, tg, "read data", d, expD);
              if (w) chk(sw == expW, tg, "write data", sw, expW);
            end
          end
        end
      end
    end
    bigEnd = 1'b0;
    setWait(0);

    // R7 peripheral legality
    for (int r = 0; r < 3; r += 2) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        issue(r, 32'hE004_0100, 1'b1, 2'(s), 32'h1, cyc, ps, e, d, sa, sw, anyV);
        chk(e == 1'b1 && cyc == 1 && !anyV, "R7", "narrow peripheral access refused",
            {e, 23'h0, 8'(cyc)}, 32'h8000_0001);
      end
    end
    dataPriv = 1'b0;
    @(negedge clk);
    issue(0, 32'hE004_0200, 1'b0, 2'b10, 32'h0, cyc, ps, e, d, sa, sw, anyV);
    chk(e == 1'b1 && cyc == 1 && !anyV, "R7", "unprivileged peripheral refused",
        {e, 23'h0, 8'(cyc)}, 32'h8000_0001);
    @(negedge clk);
    issue(2, 32'hE004_0204, 1'b0, 2'b10, 32'h0, cyc, ps, e, d, sa, sw, anyV);
    chk(e == 1'b0 && ps == 3, "R7", "debug treated as privileged", ps, 3);
    @(negedge clk);
    issue(0, 32'h2000_0008, 1'b0, 2'b10, 32'h0, cyc, ps, e, d, sa, sw, anyV);
    chk(e == 1'b0 && ps == 2, "R7", "privilege ignored off peripheral", ps, 2);
    dataPriv = 1'b1;

    // R5 system-port order
    setWait(0); waitLen[2] = 1;
    @(negedge clk);
    fork
      issue(0, 32'h2000_0010, 1'b0, 2'b10, 32'h0, c0, ps, e, d, sa, sw, anyV);
      issue(1, 32'h2000_0020, 1'b0, 2'b10, 32'h0, c1, ps, e, d, sa, sw, anyV);
      issue(2, 32'h2000_0030, 1'b0, 2'b10, 32'h0, c2, ps, e, d, sa, sw, anyV);
    join
    chk(c0 == 1, "R5", "data finish cycle", c0, 1);
    chk(c1 == 3, "R5", "fetch finish cycle", c1, 3);
    chk(c2 == 5, "R5", "debug finish cycle", c2, 5);

    // R6 data-code and peripheral ports
    setWait(0); waitLen[1] = 2;
    @(negedge clk);
    fork
      issue(0, 32'h0000_0100, 1'b0, 2'b10, 32'h0, c0, ps, e, d, sa, sw, anyV);
      issue(2, 32'h0000_0104, 1'b0, 2'b10, 32'h0, c2, ps, e, d, sa, sw, anyV);
    join
    chk(c0 == 2, "R6", "data-code data finish", c0, 2);
    chk(c2 == 5, "R6", "data-code debug finish", c2, 5);
    setWait(0);
    @(negedge clk);
    fork
      issue(0, 32'hE004_0010, 1'b0, 2'b10, 32'h0, c0, ps, e, d, sa, sw, anyV);
      issue(2, 32'hE004_0014, 1'b0, 2'b10, 32'h0, c2, ps, e, d, sa, sw, anyV);
    join
    chk(c0 == 0, "R6", "peripheral data finish", c0, 0);
    chk(c2 == 1, "R6", "peripheral debug finish", c2, 1);

    // R9 no preemption
    setWait(0); waitLen[2] = 3;
    @(negedge clk);
    fork
      issue(2, 32'h3000_0000, 1'b0, 2'b10, 32'h0, c2, ps, e, d, sa, sw, anyV);
      begin
        @(negedge clk);
        issue(0, 32'h3000_0004, 1'b0, 2'b10, 32'h0, c0, ps, e, d, sa, sw, anyV);
      end
    join
    chk(c2 == 3, "R9", "in-flight debug finish", c2, 3);
    chk(c0 == 6, "R9", "late data finish", c0, 6);

    // R11 independent ports
    setWait(0); waitLen[0] = 1; waitLen[1] = 1;
    @(negedge clk);
    fork
      issue(1, 32'h0000_0100, 1'b0, 2'b10, 32'h0, c1, ps, e, d, sa, sw, anyV);
      issue(0, 32'h0000_0200, 1'b0, 2'b10, 32'h0, c0, ps, e, d, sa, sw, anyV);
    join
    chk(c1 == 1 && c0 == 1, "R11", "fetch and data in parallel", {c1[15:0], c0[15:0]}, 32'h0001_0001);
    setWait(0);
    @(negedge clk);
    fork
      issue(0, 32'h4000_0000, 1'b0, 2'b10, 32'h0, c0, ps, e, d, sa, sw, anyV);
      issue(2, 32'hE008_0000, 1'b0, 2'b10, 32'h0, c2, ps, e, d, sa, sw, anyV);
    join
    chk(c0 == 0 && c2 == 0, "R11", "system and peripheral in parallel", {c0[15:0], c2[15:0]}, 32'h0);

    // R12 downstream error
    setWait(0); errOn[1] = 1'b1;
    @(negedge clk);
    issue(0, 32'h0000_0040, 1'b0, 2'b10, 32'h0, cyc, ps, e, d, sa, sw, anyV);
    chk(e == 1'b1 && cyc == 0, "R12", "port error forwarded", {e, 23'h0, 8'(cyc)}, 32'h8000_0000);
    errOn = '0;
    @(negedge clk);
    issue(0, 32'h0000_0044, 1'b0, 2'b10, 32'h0, cyc, ps, e, d, sa, sw, anyV);
    chk(e == 1'b0, "R12", "no error when port clean", {31'h0, e}, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule